// File: doc/BRIEF.md
# Transceiver Control Register Bank with Write Aliases

This block is a byte-wide register file for the control side of a USB transceiver. A bus master issues one access per cycle on a simple strobe interface (valid, write flag, 6-bit address, write byte). Reads return their byte one cycle later, with a valid flag. The bank holds a general-purpose scratch byte. That byte can be reached at three addresses: one loads it, one ORs bits into it, and one clears bits in it. All three read back the same value.

The bank also gathers three status inputs into an interrupt latch. These are session valid, bus-voltage valid and host disconnect. Each input is synchronized and edge-detected. An edge is recorded only when its rising or falling enable is set. Reading the latch returns its contents and empties it. A read-only debug byte shows the two live line-state signals.

One address acts as an escape into a wider 8-bit extended space, whose low 64 addresses mirror the immediate map. Every other address is a stub: it reads as zero and ignores writes.

Top module: `phy_reg_bank`

## Requirements
- R1: While reset is held and after it is released, rd_valid is 0 and rd_data is 00h. The scratch byte and the interrupt latch start at 00h.
- R2: An access executes on the clock edge at which acc_valid is sampled high, unless it belongs to an escape sequence still in progress. For a read, rd_valid is 1 and rd_data carries the byte during the following cycle. In any cycle after an edge where no read executed, rd_valid is 0 and rd_data is 00h.
- R3: A write to 16h loads the scratch byte. A read at 16h, 17h or 18h returns the scratch byte.
- R4: A write to 17h ORs the write byte into the scratch byte.
- R5: A write to 18h clears every scratch bit that is 1 in the write byte.
- R6: The latch at 14h uses bit 2 for evt_in[2] (session valid), bit 1 for evt_in[1] (bus-voltage valid) and bit 0 for evt_in[0] (host disconnect). Each input passes a 2-flop synchronizer. A rising edge sets its bit only if evt_rise_en for that bit is 1. A falling edge sets its bit only if evt_fall_en for that bit is 1. Bits 7 to 3 read 0.
- R7: A read of 14h returns the latch and then clears it. An event that lands on the same edge as the clearing read stays set.
- R8: A read of 15h returns {6'b0, line_state[1:0]} as sampled at the executing edge. Writes to 14h and 15h change nothing.
- R9: Every immediate address other than 14h to 18h and 2Fh reads 00h and ignores writes. This covers 00h to 13h, 19h to 2Eh and 30h to 3Fh.
- R10: An access at 2Fh starts an extended access and returns no read data. On the next acc_valid cycle, acc_wdata gives the extended address, and acc_addr and acc_write are ignored. A read executes on that cycle. A write takes its data from acc_wdata on the third acc_valid cycle.
- R11: Extended addresses 00h to 3Fh behave like the same immediate address. Extended 2Fh is itself a stub. Extended addresses 40h to FFh read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access strobe, one access per high cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Immediate address |
| acc_wdata | input | 8 | Write byte, or extended address during an escape |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte, 00h when not valid |
| evt_in | input | 3 | Asynchronous status inputs |
| evt_rise_en | input | 3 | Per-input rising-edge enable |
| evt_fall_en | input | 3 | Per-input falling-edge enable |
| line_state | input | 2 | Live line-state bits for the debug byte |

## Verification
The hardest case to reach from the ports is a status edge that lands on the very edge where a read of 14h clears the latch. The status input must be changed exactly two clock edges before the read executes, which accounts for the synchronizer depth. The stimulus toggles the input on a falling clock edge, counts two rising edges, and then issues the read. The bench expects the old latch contents from that read and the new bit from the read after it. Random traffic covers all three scratch aliases, the stub ranges and extended accesses, including the two-phase and three-phase escape sequences.

// File: rtl/phy_regs_pkg.sv
`timescale 1ns/1ps
package phy_regs_pkg;
  localparam int XADDR_W = 8;
  localparam int BYTE_W  = 8;

  localparam logic [5:0] OFF_INTL  = 6'h14;
  localparam logic [5:0] OFF_DBG   = 6'h15;
  localparam logic [5:0] OFF_SCR_W = 6'h16;
  localparam logic [5:0] OFF_SCR_S = 6'h17;
  localparam logic [5:0] OFF_SCR_C = 6'h18;
  localparam logic [5:0] OFF_ESC   = 6'h2F;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_XADR = 2'd1,
    SEQ_XDAT = 2'd2
  } seq_st_t;

  // One executed access, after escape handling.
  typedef struct packed {
    logic               rd;
    logic               wr;
    logic [XADDR_W-1:0] addr;
    logic [BYTE_W-1:0]  data;
  } exec_t;
endpackage

// File: rtl/phy_evt_detect.sv
`timescale 1ns/1ps
module phy_evt_detect #(
  parameter int N_EVT       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] din,
  input  logic [N_EVT-1:0] rise_en,
  input  logic [N_EVT-1:0] fall_en,
  output logic [N_EVT-1:0] pulse
);
  localparam int SH_W = SYNC_STAGES + 1;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    logic [SH_W-1:0] sh_q;
    logic [SH_W-1:0] sh_d;
    logic            rise;
    logic            fall;

    always_comb begin
      sh_d = {sh_q[SH_W-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    // Edge between the last synchronized stage and its delayed copy.
    always_comb begin
      rise     = sh_q[SH_W-2] & ~sh_q[SH_W-1];
      fall     = ~sh_q[SH_W-2] & sh_q[SH_W-1];
      pulse[i] = (rise & rise_en[i]) | (fall & fall_en[i]);
    end
  end
endmodule

// File: rtl/phy_ext_seq.sv
`timescale 1ns/1ps
module phy_ext_seq
  import phy_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output exec_t             ex
);
  seq_st_t            st_q, st_d;
  logic               wr_q, wr_d, wr_en;
  logic [XADDR_W-1:0] xa_q, xa_d;
  logic               xa_en;

  always_comb begin
    st_d    = st_q;
    wr_d    = acc_write;
    wr_en   = 1'b0;
    xa_d    = acc_wdata;
    xa_en   = 1'b0;
    ex.rd   = 1'b0;
    ex.wr   = 1'b0;
    ex.addr = XADDR_W'(acc_addr);
    ex.data = acc_wdata;
    unique case (st_q)
      SEQ_IDLE: begin
        if (acc_valid) begin
          if (acc_addr == OFF_ESC[ADDR_W-1:0]) begin
            st_d  = SEQ_XADR;
            wr_en = 1'b1;
          end else begin
            ex.rd = ~acc_write;
            ex.wr = acc_write;
          end
        end
      end
      SEQ_XADR: begin
        if (acc_valid) begin
          xa_en   = 1'b1;
          ex.addr = acc_wdata;
          if (wr_q) begin
            st_d = SEQ_XDAT;
          end else begin
            ex.rd = 1'b1;
            st_d  = SEQ_IDLE;
          end
        end
      end
      SEQ_XDAT: begin
        ex.addr = xa_q;
        if (acc_valid) begin
          ex.wr = 1'b1;
          st_d  = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
      wr_q <= 1'b0;
      xa_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_en) wr_q <= wr_d;
      if (xa_en) xa_q <= xa_d;
    end
  end
endmodule

// File: rtl/phy_reg_core.sv
`timescale 1ns/1ps
module phy_reg_core
  import phy_regs_pkg::*;
#(
  parameter int N_EVT = 3,
  parameter int LS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  exec_t             ex,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic [LS_W-1:0]   line_state,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] scratch,
  output logic [N_EVT-1:0]  latch
);
  logic              in_win;
  logic [5:0]        sel;
  logic [BYTE_W-1:0] scr_q, scr_d;
  logic              scr_en;
  logic [N_EVT-1:0]  lat_q, lat_d;
  logic              rv_q, rv_d;
  logic [BYTE_W-1:0] rdat_q, rdat_d;

  always_comb begin
    in_win = (ex.addr[XADDR_W-1:6] == '0);
    sel    = ex.addr[5:0];
  end

  // Scratch byte: load, set and clear aliases.
  always_comb begin
    scr_d  = scr_q;
    scr_en = ex.wr & in_win;
    unique case (sel)
      OFF_SCR_W: scr_d = ex.data;
      OFF_SCR_S: scr_d = scr_q | ex.data;
      OFF_SCR_C: scr_d = scr_q & ~ex.data;
      default:   scr_d = scr_q;
    endcase
  end

  // Interrupt latch: a clearing read keeps events of the same edge.
  always_comb begin
    if (ex.rd && in_win && sel == OFF_INTL) lat_d = evt_pulse;
    else                                    lat_d = lat_q | evt_pulse;
  end

  always_comb begin
    rv_d   = ex.rd;
    rdat_d = '0;
    if (ex.rd && in_win) begin
      unique case (sel)
        OFF_INTL:                      rdat_d[N_EVT-1:0] = lat_q;
        OFF_DBG:                       rdat_d[LS_W-1:0]  = line_state;
        OFF_SCR_W, OFF_SCR_S, OFF_SCR_C: rdat_d          = scr_q;
        default:                       rdat_d            = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q  <= '0;
      lat_q  <= '0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      if (scr_en) scr_q <= scr_d;
      lat_q  <= lat_d;
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = rdat_q;
  assign scratch  = scr_q;
  assign latch    = lat_q;
endmodule

// File: rtl/phy_reg_bank.sv
`timescale 1ns/1ps
module phy_reg_bank
  import phy_regs_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int N_EVT       = 3,
  parameter int LS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic [N_EVT-1:0]  evt_rise_en,
  input  logic [N_EVT-1:0]  evt_fall_en,
  input  logic [LS_W-1:0]   line_state
);
  logic [1:0]        rs_q;
  logic              rst_sync_n;
  exec_t             ex;
  logic [N_EVT-1:0]  evt_pulse;
  logic [BYTE_W-1:0] scratch;
  logic [N_EVT-1:0]  latch;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  phy_evt_detect #(.N_EVT(N_EVT), .SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .din     (evt_in),
    .rise_en (evt_rise_en),
    .fall_en (evt_fall_en),
    .pulse   (evt_pulse)
  );

  phy_ext_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .ex        (ex)
  );

  phy_reg_core #(.N_EVT(N_EVT), .LS_W(LS_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ex         (ex),
    .evt_pulse  (evt_pulse),
    .line_state (line_state),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .scratch    (scratch),
    .latch      (latch)
  );
endmodule

// File: rtl/phy_reg_bank_chk.sv
`timescale 1ns/1ps
module phy_reg_bank_chk
  import phy_regs_pkg::*;
#(
  parameter int N_EVT = 3,
  parameter int LS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input exec_t             ex,
  input logic [N_EVT-1:0]  evt_pulse,
  input logic [LS_W-1:0]   line_state,
  input logic [BYTE_W-1:0] scratch,
  input logic [N_EVT-1:0]  latch,
  input logic              rd_valid,
  input logic [BYTE_W-1:0] rd_data
);
  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ex.rd |=> rd_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ex.rd |=> !rd_valid);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.wr && ex.addr == 8'h16) |=> scratch == $past(ex.data));
  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.wr && ex.addr == 8'h17) |=> (scratch & $past(ex.data)) == $past(ex.data));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.wr && ex.addr == 8'h18) |=> (scratch & $past(ex.data)) == '0);
  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> (latch & $past(evt_pulse)) == $past(evt_pulse));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.rd && ex.addr == 8'h14) |=> latch == $past(evt_pulse));
  assert_debug_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.rd && ex.addr == 8'h15) |=> rd_data == BYTE_W'($past(line_state)));
  assert_stub_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.wr && (ex.addr < 8'h16 || ex.addr > 8'h18)) |=> $stable(scratch));
  assert_ext_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ex.rd && ex.addr >= 8'h40) |=> rd_data == '0);
endmodule

bind phy_reg_bank phy_reg_bank_chk #(.N_EVT(N_EVT), .LS_W(LS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ex         (ex),
  .evt_pulse  (evt_pulse),
  .line_state (line_state),
  .scratch    (scratch),
  .latch      (latch),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data)
);

// File: tb/tb_phy_reg_bank.sv
`timescale 1ns/1ps
module tb_phy_reg_bank;
  logic       clk;
  logic       rst_n;
  logic       acc_valid, acc_write;
  logic [5:0] acc_addr;
  logic [7:0] acc_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [2:0] evt_in, evt_rise_en, evt_fall_en;
  logic [1:0] line_state;

  int   nvec = 0;
  int   nbad = 0;
  bit   done = 0;
  logic [7:0] m_scr;

  phy_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .evt_in(evt_in), .evt_rise_en(evt_rise_en),
    .evt_fall_en(evt_fall_en), .line_state(line_state)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Expected read value with no pending events (latch empty).
  function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic [1:0] ls);
    if (a >= 8'h40) return 8'h00;
    case (a[5:0])
      6'h15:               return {6'b0, ls};
      6'h16, 6'h17, 6'h18: return m_scr;
      default:             return 8'h00;
    endcase
  endfunction

  function automatic void m_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h16)      m_scr = d;
    else if (a == 8'h17) m_scr = m_scr | d;
    else if (a == 8'h18) m_scr = m_scr & ~d;
  endfunction

  task automatic imm_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R2 no read data after write", {7'b0, rd_valid}, 8'h00);
    m_write({2'b00, a}, d);
  endtask

  task automatic imm_rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_wdata = 8'($urandom);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R2 rd_valid", {7'b0, rd_valid}, 8'h01);
    chk(tag, rd_data, exp);
  endtask

  task automatic ext_rd(input logic [7:0] x, input logic [7:0] exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 6'h2F;
    @(negedge clk);
    chk("R10 escape gives no data", {7'b0, rd_valid}, 8'h00);
    acc_write = 1'($urandom); acc_addr = 6'($urandom); acc_wdata = x;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R10 ext rd_valid", {7'b0, rd_valid}, 8'h01);
    chk(tag, rd_data, exp);
  endtask

  task automatic ext_wr(input logic [7:0] x, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 6'h2F;
    @(negedge clk);
    acc_write = 1'($urandom); acc_addr = 6'($urandom); acc_wdata = x;
    @(negedge clk);
    acc_write = 1'($urandom); acc_addr = 6'($urandom); acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R10 no read data on ext write", {7'b0, rd_valid}, 8'h00);
    if (x != 8'h2F) m_write(x, d);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    evt_in = '0; evt_rise_en = '0; evt_fall_en = '0; line_state = '0;
    m_scr = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 rd_valid in reset", {7'b0, rd_valid}, 8'h00);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_data after release", rd_data, 8'h00);
    imm_rd(6'h16, 8'h00, "R1 scratch reset");
    imm_rd(6'h14, 8'h00, "R1 latch reset");
    @(negedge clk);
    chk("R2 idle rd_valid", {7'b0, rd_valid}, 8'h00);
    chk("R2 idle rd_data", rd_data, 8'h00);

    // Scratch aliases, directed.
    imm_wr(6'h16, 8'hA5); imm_rd(6'h16, 8'hA5, "R3 load");
    imm_wr(6'h17, 8'h5A); imm_rd(6'h17, 8'hFF, "R4 set");
    imm_wr(6'h18, 8'h0F); imm_rd(6'h18, 8'hF0, "R5 clear");
    imm_wr(6'h18, 8'h00); imm_rd(6'h16, 8'hF0, "R5 clear with zero mask");

    // Debug byte and read-only registers.
    line_state = 2'b10; imm_rd(6'h15, 8'h02, "R8 debug 10");
    line_state = 2'b01; imm_rd(6'h15, 8'h01, "R8 debug 01");
    imm_wr(6'h14, 8'hFF); imm_wr(6'h15, 8'hFF);
    imm_rd(6'h14, 8'h00, "R8 write to latch ignored");
    imm_rd(6'h16, m_scr, "R8 read-only writes leave scratch");

    // Stub ranges.
    imm_wr(6'h1C, 8'h00); imm_wr(6'h3A, 8'h00); imm_wr(6'h05, 8'h00);
    imm_rd(6'h16, m_scr, "R9 stub writes ignored");
    imm_rd(6'h2E, 8'h00, "R9 read 2Eh");
    imm_rd(6'h30, 8'h00, "R9 read 30h");
    imm_rd(6'h13, 8'h00, "R9 read 13h");

    // Extended space.
    ext_wr(8'h16, 8'h3C); ext_rd(8'h16, 8'h3C, "R11 ext alias load");
    ext_wr(8'h17, 8'h81); imm_rd(6'h18, 8'hBD, "R11 ext set seen immediate");
    ext_wr(8'h56, 8'h00); ext_rd(8'h18, m_scr, "R11 ext high write ignored");
    ext_rd(8'hC4, 8'h00, "R11 ext high read");
    ext_rd(8'h2F, 8'h00, "R11 ext 2Fh stub");
    line_state = 2'b11; ext_rd(8'h15, 8'h03, "R11 ext debug alias");

    // Events.
    evt_rise_en = 3'b111; evt_fall_en = 3'b000;
    @(negedge clk); evt_in[1] = 1'b1; settle();
    imm_rd(6'h14, 8'h02, "R6 bus-voltage rise");
    imm_rd(6'h14, 8'h00, "R7 cleared by read");
    @(negedge clk); evt_in[1] = 1'b0; settle();
    imm_rd(6'h14, 8'h00, "R6 fall not enabled");
    evt_rise_en = 3'b011;
    @(negedge clk); evt_in[2] = 1'b1; settle();
    imm_rd(6'h14, 8'h00, "R6 rise masked");
    evt_fall_en = 3'b100;
    @(negedge clk); evt_in[2] = 1'b0; settle();
    imm_rd(6'h14, 8'h04, "R6 session fall");
    evt_rise_en = 3'b111; evt_fall_en = 3'b000;
    @(negedge clk); evt_in[0] = 1'b1; settle();
    // Session rise lands on the same edge as the clearing read.
    @(negedge clk); evt_in[2] = 1'b1;
    @(posedge clk); @(posedge clk);
    imm_rd(6'h14, 8'h01, "R7 read during event returns old");
    imm_rd(6'h14, 8'h04, "R7 coincident event kept");
    imm_rd(6'h14, 8'h00, "R7 empty after");

    // Random traffic (no status edges from here on).
    evt_rise_en = 3'b000;
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      int kind;
      int op;
      kind = $urandom_range(0, 3);
      op   = $urandom_range(0, 3);
      d    = 8'($urandom);
      if (kind == 0)      a = 8'h16 + 8'($urandom_range(0, 2));
      else if (kind == 1) a = 8'($urandom_range(0, 63));
      else if (kind == 2) a = 8'h15;
      else                a = 8'($urandom);
      line_state = 2'($urandom);
      if (op >= 2 && a == 8'h2F) a = 8'h2E;
      if (op >= 2 && a >= 8'h40) a = {2'b00, a[5:0]};
      if (op >= 2 && a == 8'h2F) a = 8'h2E;
      case (op)
        0: ext_wr(a, d);
        1: ext_rd(a, exp_rd(a, line_state), "R11 random ext read");
        2: imm_wr(a[5:0], d);
        default: imm_rd(a[5:0], exp_rd(a, line_state), "R3 random immediate read");
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule